// File: doc/BRIEF.md
# External Bus Release and Idle Controller

This controller decides who owns an external memory bus and when a dead state must separate two external accesses. Internal masters present one access at a time: a request, an area number and a read flag. The controller accepts the access by raising a go pulse. An external master may ask for the bus. If release is allowed by software, the controller hands the bus over between accesses and keeps it away until that master lets go. While the bus is away, the controller can signal back to the external master that internal work or a refresh is waiting.

Two reads in a row that hit different areas can need recovery time on the shared data lines. The controller keeps a record of the last accepted access and inserts one or two idle states before the go pulse when this case occurs. A small control register holds the enables and the idle settings.

Top module: `xbus_release_ctrl`

## Requirements
- R1: After reset the control register reads 5'b11000 (bit 4 idle insert = 1, bit 3 idle length = 1, bit 2 spare = 0, bit 1 request-out enable = 0, bit 0 release enable = 0), and acc_go, idle_out, ext_back and ext_breqo are 0.
- R2: A cycle with cfg_we high loads cfg_wdata into the control register, and cfg_rdata shows the new value from the next cycle. This includes the spare bit 2.
- R3: When the controller is free and no idle is needed, acc_go rises one cycle after acc_req is seen. acc_go is a single-cycle pulse, and the access is taken at the edge where acc_req and acc_go are both high.
- R4: While bit 0 is 0, ext_breq has no effect. ext_back stays 0 and accesses still get acc_go.
- R5: While bit 0 is 1, ext_back rises only when neither acc_go nor idle_out is high. Once raised, it stays high for as long as ext_breq is high and falls one cycle after ext_breq drops.
- R6: An access requested while ext_back is high gets no acc_go. If no idle is needed, acc_go rises exactly one cycle after ext_back falls.
- R7: While ext_back is high and ext_breq is high, ext_breqo follows, one cycle later, bit 1 AND (acc_req OR refresh_req). At all other times ext_breqo is 0.
- R8: A read that follows an accepted read to a different area, with bit 4 at 1, is preceded by idle_out high for 1 cycle (bit 3 = 0) or 2 cycles (bit 3 = 1). acc_go follows directly after the idle.
- R9: No idle is inserted when bit 4 is 0, when both reads target the same area, when the new access is a write, or when the previous access was a write.
- R10: The spare bit 2 has no effect on idle insertion or on access timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write value |
| cfg_rdata | output | CFG_W | Control register contents |
| acc_req | input | 1 | Internal external-space access request, held until accepted |
| acc_area | input | AREA_W | Area number of the requested access |
| acc_rd | input | 1 | 1 for read, 0 for write |
| acc_go | output | 1 | Access accepted and started this cycle |
| idle_out | output | 1 | Idle state being inserted |
| ext_breq | input | 1 | Bus request from the external master |
| ext_back | output | 1 | Bus acknowledge to the external master |
| refresh_req | input | 1 | Refresh request pending |
| ext_breqo | output | 1 | Request toward the external master while released |

## Verification
The assertions assume that a requester holds acc_req, acc_area and acc_rd steady until acc_go has been seen, and that the idle length bit does not change while an idle is running. The bench drives every input on the falling edge. It keeps each request asserted through the cycle in which acc_go is high and drops it right after. It writes the control register only while no access or idle is in progress.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  localparam int CFG_W = 5;

  typedef struct packed {
    logic idle_ins;   // bit 4
    logic idle_len;   // bit 3
    logic spare;      // bit 2
    logic reqo_en;    // bit 1
    logic rel_en;     // bit 0
  } xbr_cfg_t;

  localparam xbr_cfg_t CFG_RST = '{idle_ins: 1'b1, idle_len: 1'b1, spare: 1'b0,
                                   reqo_en: 1'b0, rel_en: 1'b0};
endpackage

// File: rtl/xbr_cfg_reg.sv
module xbr_cfg_reg
  import xbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output xbr_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= CFG_RST;
    else if (we) cfg <= xbr_cfg_t'(wdata);
  end

  // R2: a write shows up in the register on the following cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg == xbr_cfg_t'($past(wdata))));
endmodule

// File: rtl/xbr_hist.sv
module xbr_hist #(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic [AREA_W-1:0] area,
  input  logic              rd,
  input  logic              idle_ins,
  output logic              need_idle
);
  logic              last_vld;
  logic              last_rd;
  logic [AREA_W-1:0] last_area;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_vld  <= 1'b0;
      last_rd   <= 1'b0;
      last_area <= '0;
    end else if (xfer) begin
      last_vld  <= 1'b1;
      last_rd   <= rd;
      last_area <= area;
    end
  end

  assign need_idle = idle_ins && last_vld && last_rd && rd && (area != last_area);
endmodule

// File: rtl/xbr_seq.sv
module xbr_seq (
  input  logic clk,
  input  logic rst,
  input  logic rel_en,
  input  logic reqo_en,
  input  logic idle_len,
  input  logic acc_req,
  input  logic need_idle,
  input  logic ext_breq,
  input  logic refresh_req,
  output logic acc_go,
  output logic idle_out,
  output logic ext_back,
  output logic ext_breqo
);
  logic idle_more;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_go    <= 1'b0;
      idle_out  <= 1'b0;
      idle_more <= 1'b0;
      ext_back  <= 1'b0;
      ext_breqo <= 1'b0;
    end else if (ext_back) begin
      if (!ext_breq) begin
        ext_back  <= 1'b0;
        ext_breqo <= 1'b0;
      end else begin
        ext_breqo <= reqo_en && (acc_req || refresh_req);
      end
    end else if (idle_out) begin
      if (idle_more) begin
        idle_more <= 1'b0;
      end else begin
        idle_out <= 1'b0;
        acc_go   <= 1'b1;
      end
    end else if (acc_go) begin
      acc_go <= 1'b0;
    end else if (rel_en && ext_breq) begin
      ext_back <= 1'b1;
    end else if (acc_req) begin
      if (need_idle) begin
        idle_out  <= 1'b1;
        idle_more <= idle_len;
      end else begin
        acc_go <= 1'b1;
      end
    end
  end

  // R3: go lasts a single cycle
  a_r3_go_pulse: assert property (@(posedge clk) disable iff (rst)
    acc_go |=> !acc_go);
  // R4: with release disabled the bus is never handed over
  a_r4_no_grant: assert property (@(posedge clk) disable iff (rst)
    (!rel_en && !ext_back) |=> !ext_back);
  // R5: acknowledge never overlaps an access or an idle
  a_r5_boundary: assert property (@(posedge clk) disable iff (rst)
    ext_back |-> (!acc_go && !idle_out));
  // R5: acknowledge held while the external request stays high
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (ext_back && ext_breq) |=> ext_back);
  // R5: acknowledge is granted only from a free cycle
  a_r5_grant_free: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_back) |-> $past(!acc_go && !idle_out));
  // R6: no access starts in the cycle the acknowledge drops
  a_r6_resume: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_back) |-> !acc_go);
  // R7: request output only while released
  a_r7_breqo: assert property (@(posedge clk) disable iff (rst)
    ext_breqo |-> ext_back);
  // R8: idle never longer than two cycles
  a_r8_idle_max: assert property (@(posedge clk) disable iff (rst)
    (idle_out && $past(idle_out)) |=> !idle_out);
  // R8: one-state idle when the length bit is 0
  a_r8_idle_one: assert property (@(posedge clk) disable iff (rst)
    ($rose(idle_out) && !$past(idle_len)) |=> !idle_out);
  // R8: go follows the idle directly
  a_r8_idle_go: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_out) |-> acc_go);
endmodule

// File: rtl/xbus_release_ctrl.sv
module xbus_release_ctrl
  import xbr_pkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              acc_req,
  input  logic [AREA_W-1:0] acc_area,
  input  logic              acc_rd,
  output logic              acc_go,
  output logic              idle_out,
  input  logic              ext_breq,
  output logic              ext_back,
  input  logic              refresh_req,
  output logic              ext_breqo
);
  xbr_cfg_t cfg;
  logic     need_idle;

  xbr_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  assign cfg_rdata = cfg;

  xbr_hist #(.AREA_W(AREA_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .xfer      (acc_req && acc_go),
    .area      (acc_area),
    .rd        (acc_rd),
    .idle_ins  (cfg.idle_ins),
    .need_idle (need_idle)
  );

  xbr_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .rel_en      (cfg.rel_en),
    .reqo_en     (cfg.reqo_en),
    .idle_len    (cfg.idle_len),
    .acc_req     (acc_req),
    .need_idle   (need_idle),
    .ext_breq    (ext_breq),
    .refresh_req (refresh_req),
    .acc_go      (acc_go),
    .idle_out    (idle_out),
    .ext_back    (ext_back),
    .ext_breqo   (ext_breqo)
  );
endmodule

// File: tb/xbus_release_ctrl_bench.sv
module xbus_release_ctrl_bench;
  localparam int AREA_W = 3;
  localparam int NVEC   = 10;
  // {cfg[7:0], area[3:0], rd, 0, latency[1:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1819, 16'h182B, 16'h1829, 16'h103A, 16'h1031,
    16'h1049, 16'h0859, 16'h146A, 16'h1C7B, 16'h1801
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic acc_req = 1'b0;
  logic [AREA_W-1:0] acc_area = '0;
  logic acc_rd = 1'b0;
  logic acc_go, idle_out, ext_back, ext_breqo;
  logic ext_breq = 1'b0;
  logic refresh_req = 1'b0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xbus_release_ctrl #(.AREA_W(AREA_W)) u_xbus_release_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_req(acc_req), .acc_area(acc_area), .acc_rd(acc_rd), .acc_go(acc_go),
    .idle_out(idle_out), .ext_breq(ext_breq), .ext_back(ext_back),
    .refresh_req(refresh_req), .ext_breqo(ext_breqo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(input logic [AREA_W-1:0] a, input logic r,
                           output int lat, output int idles);
    acc_req = 1'b1; acc_area = a; acc_rd = r;
    lat = 0; idles = 0;
    do begin
      @(negedge clk);
      lat++;
      if (idle_out) idles++;
    end while (!acc_go && lat < 10);
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, idles;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 5'h18, "R1 cfg", cfg_rdata, 5'h18);
    check({acc_go, idle_out, ext_back, ext_breqo} == 4'b0, "R1 outputs",
          {acc_go, idle_out, ext_back, ext_breqo}, 0);
    // R2 register write incl. spare bit
    cfg_wr(5'h1F);
    check(cfg_rdata == 5'h1F, "R2 readback", cfg_rdata, 5'h1F);
    cfg_wr(5'h04);
    check(cfg_rdata == 5'h04, "R2 spare", cfg_rdata, 5'h04);

    // vector table: R3, R8, R9, R10
    for (int i = 0; i < NVEC; i++) begin
      cfg_wr(VEC[i][12:8]);
      do_access(VEC[i][AREA_W+3:4], VEC[i][3], lat, idles);
      check(lat == int'(VEC[i][1:0]), "R8/R9/R10/R3 latency", lat, VEC[i][1:0]);
      check(idles == int'(VEC[i][1:0]) - 1, "R8/R9 idle cycles", idles, VEC[i][1:0] - 1);
    end

    // R4: release disabled
    cfg_wr(5'h18);
    ext_breq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ext_back == 1'b0, "R4 ignored", ext_back, 0);
    end
    do_access(3'd1, 1'b0, lat, idles);
    check(lat == 1, "R4 access proceeds", lat, 1);
    ext_breq = 1'b0;

    // R5, R6, R7: release with request output enabled
    cfg_wr(5'h1B);
    ext_breq = 1'b1;
    @(negedge clk);
    check(ext_back == 1'b1, "R5 grant", ext_back, 1);
    refresh_req = 1'b1;
    @(negedge clk);
    check(ext_breqo == 1'b1, "R7 refresh", ext_breqo, 1);
    refresh_req = 1'b0;
    @(negedge clk);
    check(ext_breqo == 1'b0, "R7 drop", ext_breqo, 0);
    acc_req = 1'b1; acc_area = 3'd2; acc_rd = 1'b0;
    @(negedge clk);
    check(ext_breqo == 1'b1, "R7 access pending", ext_breqo, 1);
    check(acc_go == 1'b0, "R6 stalled", acc_go, 0);
    @(negedge clk);
    check(ext_back == 1'b1, "R5 hold", ext_back, 1);
    check(acc_go == 1'b0, "R6 still stalled", acc_go, 0);
    ext_breq = 1'b0;
    @(negedge clk);
    check(ext_back == 1'b0, "R5 release", ext_back, 0);
    check(ext_breqo == 1'b0, "R7 off", ext_breqo, 0);
    check(acc_go == 1'b0, "R6 not same cycle", acc_go, 0);
    @(negedge clk);
    check(acc_go == 1'b1, "R6 resume", acc_go, 1);
    @(negedge clk);
    acc_req = 1'b0;

    // R5: request arriving during an access waits for the boundary
    acc_req = 1'b1; acc_area = 3'd3; acc_rd = 1'b0;
    @(negedge clk);
    check(acc_go == 1'b1, "R3 go", acc_go, 1);
    ext_breq = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
    check(ext_back == 1'b0, "R5 no grant mid access", ext_back, 0);
    @(negedge clk);
    check(ext_back == 1'b1, "R5 grant at boundary", ext_back, 1);
    ext_breq = 1'b0;
    @(negedge clk);
    check(ext_back == 1'b0, "R5 release 2", ext_back, 0);

    // R7: request output disabled
    cfg_wr(5'h01);
    ext_breq = 1'b1;
    @(negedge clk);
    check(ext_back == 1'b1, "R5 grant 3", ext_back, 1);
    refresh_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ext_breqo == 1'b0, "R7 disabled", ext_breqo, 0);
    refresh_req = 1'b0;
    ext_breq = 1'b0;
    @(negedge clk);
    check(ext_back == 1'b0, "R5 release 3", ext_back, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule